// File: doc/BRIEF.md
# Serial Antenna-Switch Control Slave

This block is the digital front end of a dual-band antenna switch. It listens on a two-wire serial bus made of a clock line driven by the bus master and a bidirectional data line. It picks out command sequences addressed to its own programmable slave ID and keeps the switch-state registers that set the high-band and low-band RF paths. The data line is split into an input, an output and an output enable, so the pad ring can build the tristate driver.

Both bus lines are brought into the block's system clock through synchronizers and are handled as oversampled events. New switch states are first written to a shadow copy. They reach the switch-select outputs only when a trigger is fired or when that band's trigger mask is set. Any protocol fault discards the command and sets a flag in a status register that clears when read. A software reset returns both switch states to zero. It leaves the slave ID and the trigger/power-mode settings as they are.

Top module: `rffeSwitchSlave`

## Requirements
- R1: A sequence starts when SDATA rises and then falls while SCLK stays low. Bits are then taken on SCLK falling edges, MSB first. The command frame is 13 bits: slave ID[3:0], command[7:0] and a parity bit that makes the frame's count of ones odd. Command 1ddddddd is the compact high-band write, 010aaaaa is a register write, and 011aaaaa is a register read (aaaaa is the register address).
- R2: The compact write stores its 7 data bits in the high-band shadow (address 0x00) with bit 7 cleared. A register write to 0x00 stores all 8 bits.
- R3: The low-band shadow at address 0x01 is written by a register write followed by a data frame of 8 bits, MSB first, plus an odd-parity bit. It can be read back.
- R4: Writing the trigger register at address 0x1C with bit 0 set copies the high-band shadow to the active high-band state. Bit 1 does the same for low band and bit 2 does it for both. The trigger bits read back as 0. hbSel and lbSel show the active states, and a shadow write alone leaves them unchanged.
- R5: Bit 3 of register 0x1C (high band) and bit 4 (low band) are masks. While a band's mask is set, writes to that band go straight to its active state as well.
- R6: Bits [7:6] of register 0x1C are the power mode. Any nonzero value forces hbSel and lbSel to 0. The active states are kept and come back when the mode returns to 0.
- R7: After a read command the master drives one park cycle. The slave then drives 8 data bits and an odd-parity bit, each starting on an SCLK rising edge. It then drives 0 for one further cycle and releases SDATA on that cycle's falling edge.
- R8: A command-frame parity error or a data-frame parity error discards the command, and no register changes.
- R9: The status register at address 0x1B has these flags: bit 0 command parity error, bit 1 length error, bit 2 data parity error, bit 3 read of an invalid address, bit 4 write of an invalid address. A length error is a start condition in the middle of a sequence; the new sequence then proceeds. A read returns the flags and then clears them.
- R10: The valid addresses are 0x00, 0x01, 0x1A, 0x1B, 0x1C and 0x1F. A write to any other address is discarded. A read of any other address gets no response on SDATA.
- R11: A command whose slave ID differs from the current ID is ignored and sets no flag.
- R12: Bits [3:0] of register 0x1F hold the slave ID. It resets to 4'b1011 and a new value applies from the next command.
- R13: Writing register 0x1A with bit 6 set clears both shadow and active switch states. Register 0x1C and the slave ID are left unchanged, and 0x1A reads back as 0.
- R14: During reset hbSel and lbSel are 0 and SDATA is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bus clock from the master |
| sdataIn | input | 1 | Resolved level of the serial data line |
| sdataOut | output | 1 | Data driven by the slave during read replies |
| sdataOe | output | 1 | Output enable for the slave's SDATA driver |
| hbSel | output | 8 | Active high-band switch state |
| lbSel | output | 8 | Active low-band switch state |

## Verification
The checks assume that each SCLK half-period is longer than the synchronizer delay plus two system clocks. Under that assumption the slave's driver turns on while SCLK is still high and turns off while it is still low. They also assume that the master changes SDATA only while SCLK is high, except when it makes the start condition, and that it releases the line whenever the slave drives it. The bench drives SCLK with eight system clocks per half-period and changes SDATA together with each SCLK rise. It makes the start pulse only while SCLK is low, and it floats its driver for the whole read reply.

// File: rtl/rffe_sw_pkg.sv
package rffe_sw_pkg;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 5;
  localparam int USID_W     = 4;
  localparam int CMD_W      = 8;
  localparam int CMD_BITS   = USID_W + CMD_W + 1;
  localparam int DATA_BITS  = REG_W + 1;
  localparam int NUM_BANDS  = 2;
  localparam int NUM_ERR    = 5;

  localparam logic [ADDR_W-1:0] ADDR_HB     = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_LB     = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'h1A;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 5'h1B;
  localparam logic [ADDR_W-1:0] ADDR_PM     = 5'h1C;
  localparam logic [ADDR_W-1:0] ADDR_USID   = 5'h1F;

  localparam int TRIG_ALL   = 2;
  localparam int MASK_LSB   = 3;
  localparam int SPARE_BIT  = 5;
  localparam int SWRST_BIT  = 6;

  localparam int ERR_CMDPAR = 0;
  localparam int ERR_LEN    = 1;
  localparam int ERR_DATPAR = 2;
  localparam int ERR_RDINV  = 3;
  localparam int ERR_WRINV  = 4;

  typedef struct packed {
    logic               wrEn;
    logic               rdEn;
    logic [ADDR_W-1:0]  addr;
    logic [REG_W-1:0]   data;
    logic [NUM_ERR-1:0] errSet;
  } regStrobe_t;

  function automatic logic addrValid(input logic [ADDR_W-1:0] a);
    return (a == ADDR_HB) || (a == ADDR_LB) || (a == ADDR_CTRL) ||
           (a == ADDR_STATUS) || (a == ADDR_PM) || (a == ADDR_USID);
  endfunction
endpackage

// File: rtl/rffeCtrl.sv
module rffeCtrl import rffe_sw_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              sdataIn,
  input  logic [USID_W-1:0] usid,
  input  logic [REG_W-1:0]  rdData,
  output regStrobe_t        strobe,
  output logic              sdataOut,
  output logic              sdataOe
);
  localparam int CNT_W = $clog2(CMD_BITS + 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_BITS - 1);

  typedef enum logic [2:0] {IDLE, CMD, WDATA, RPARK, RDRV, REND} ctrlState_t;

  logic [SYNC_STAGES:0] sclkPipe, sdatPipe;
  logic sclkS, sclkP, sdatS, sdatP, sclkFall, sclkRise, sscArm, ssc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      sdatPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      sdatPipe <= {sdatPipe[SYNC_STAGES-1:0], sdataIn};
    end
  end

  assign sclkS    = sclkPipe[SYNC_STAGES-1];
  assign sclkP    = sclkPipe[SYNC_STAGES];
  assign sdatS    = sdatPipe[SYNC_STAGES-1];
  assign sdatP    = sdatPipe[SYNC_STAGES];
  assign sclkFall = sclkP & ~sclkS;
  assign sclkRise = ~sclkP & sclkS;
  assign ssc      = sscArm & ~sclkS & sdatP & ~sdatS;

  // start detection: data high-then-low with the clock held low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     sscArm <= 1'b0;
    else if (sclkS || ssc)         sscArm <= 1'b0;
    else if (sdatS && !sdatP)      sscArm <= 1'b1;
  end

  ctrlState_t state;
  logic [CNT_W-1:0]     bitCnt;
  logic [CMD_BITS-2:0]  shReg;
  logic [ADDR_W-1:0]    addrQ;
  logic [DATA_BITS-1:0] rdSh;

  logic [CMD_BITS-1:0]  cmdFull;
  logic [DATA_BITS-1:0] datFull;
  logic [USID_W-1:0]    frmUsid;
  logic [CMD_W-1:0]     cmdByte;
  logic cmdDone, datDone, idMatch, cmdParOk, datParOk, goWrite, goRead;

  always_comb begin
    cmdFull  = {shReg, sdatS};
    datFull  = {shReg[DATA_BITS-2:0], sdatS};
    frmUsid  = cmdFull[CMD_BITS-1 -: USID_W];
    cmdByte  = cmdFull[CMD_W:1];
    cmdParOk = ^cmdFull;
    datParOk = ^datFull;
    cmdDone  = (state == CMD) && sclkFall && (bitCnt == CMD_LAST);
    datDone  = (state == WDATA) && sclkFall && (bitCnt == DAT_LAST);
    idMatch  = (frmUsid == usid);
    goWrite  = cmdDone && idMatch && cmdParOk && (cmdByte[7:5] == 3'b010) &&
               addrValid(cmdByte[ADDR_W-1:0]);
    goRead   = cmdDone && idMatch && cmdParOk && (cmdByte[7:5] == 3'b011) &&
               addrValid(cmdByte[ADDR_W-1:0]);

    strobe      = '0;
    strobe.addr = addrQ;
    if (ssc && state != IDLE) strobe.errSet[ERR_LEN] = 1'b1;
    if (cmdDone && idMatch) begin
      strobe.addr = cmdByte[ADDR_W-1:0];
      if (!cmdParOk) begin
        strobe.errSet[ERR_CMDPAR] = 1'b1;
      end else if (cmdByte[7]) begin
        strobe.wrEn = 1'b1;
        strobe.addr = ADDR_HB;
        strobe.data = {1'b0, cmdByte[6:0]};
      end else if (cmdByte[7:5] == 3'b010) begin
        strobe.errSet[ERR_WRINV] = !addrValid(cmdByte[ADDR_W-1:0]);
      end else if (cmdByte[7:5] == 3'b011) begin
        strobe.rdEn = addrValid(cmdByte[ADDR_W-1:0]);
        strobe.errSet[ERR_RDINV] = !addrValid(cmdByte[ADDR_W-1:0]);
      end
    end
    if (datDone) begin
      strobe.data = datFull[DATA_BITS-1:1];
      if (datParOk) strobe.wrEn = 1'b1;
      else          strobe.errSet[ERR_DATPAR] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= IDLE;
      bitCnt   <= '0;
      shReg    <= '0;
      addrQ    <= '0;
      rdSh     <= '0;
      sdataOut <= 1'b0;
      sdataOe  <= 1'b0;
    end else if (ssc) begin
      state  <= CMD;
      bitCnt <= '0;
    end else begin
      unique case (state)
        CMD: if (sclkFall) begin
          shReg  <= {shReg[CMD_BITS-3:0], sdatS};
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CMD_LAST) begin
            bitCnt <= '0;
            addrQ  <= cmdByte[ADDR_W-1:0];
            rdSh   <= {rdData, ~^rdData};
            state  <= goWrite ? WDATA : (goRead ? RPARK : IDLE);
          end
        end
        WDATA: if (sclkFall) begin
          shReg  <= {shReg[CMD_BITS-3:0], sdatS};
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == DAT_LAST) state <= IDLE;
        end
        RPARK: if (sclkFall) begin
          state  <= RDRV;
          bitCnt <= DAT_LAST;
        end
        RDRV: begin
          if (sclkRise) begin
            sdataOut <= rdSh[bitCnt];
            sdataOe  <= 1'b1;
          end
          if (sclkFall) begin
            if (bitCnt == '0) state <= REND;
            else              bitCnt <= bitCnt - 1'b1;
          end
        end
        REND: begin
          if (sclkRise) sdataOut <= 1'b0;
          if (sclkFall) begin
            sdataOe <= 1'b0;
            state   <= IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rffeRegs.sv
module rffeRegs import rffe_sw_pkg::*; #(
  parameter logic [USID_W-1:0] USID_DEFAULT = 4'b1011
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  output logic [REG_W-1:0]  rdData,
  output logic [USID_W-1:0] usid,
  output logic [REG_W-1:0]  hbSel,
  output logic [REG_W-1:0]  lbSel
);
  logic [1:0]           pmMode;
  logic                 spareQ;
  logic [NUM_BANDS-1:0] maskQ;
  logic [NUM_ERR-1:0]   statusQ;
  logic [NUM_BANDS-1:0][REG_W-1:0] shdVec, actVec;

  logic pmWr, swRst;
  assign pmWr  = strobe.wrEn && (strobe.addr == ADDR_PM);
  assign swRst = strobe.wrEn && (strobe.addr == ADDR_CTRL) && strobe.data[SWRST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pmMode <= '0;
      spareQ <= 1'b0;
      maskQ  <= '0;
      usid   <= USID_DEFAULT;
    end else begin
      if (pmWr) begin
        pmMode <= strobe.data[7:6];
        spareQ <= strobe.data[SPARE_BIT];
        maskQ  <= strobe.data[MASK_LSB +: NUM_BANDS];
      end
      if (strobe.wrEn && strobe.addr == ADDR_USID) usid <= strobe.data[USID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else statusQ <= ((strobe.rdEn && strobe.addr == ADDR_STATUS) ? '0 : statusQ)
                    | strobe.errSet;
  end

  for (genvar b = 0; b < NUM_BANDS; b++) begin : bandG
    logic [REG_W-1:0] shdQ, actQ;
    logic bandWr, fire;
    assign bandWr = strobe.wrEn && (strobe.addr == ADDR_HB + ADDR_W'(b));
    assign fire   = pmWr && (strobe.data[b] || strobe.data[TRIG_ALL]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shdQ <= '0;
        actQ <= '0;
      end else if (swRst) begin
        shdQ <= '0;
        actQ <= '0;
      end else if (bandWr) begin
        shdQ <= strobe.data;
        if (maskQ[b]) actQ <= strobe.data;
      end else if (fire) begin
        actQ <= shdQ;
      end
    end
    assign shdVec[b] = shdQ;
    assign actVec[b] = (pmMode == 2'b00) ? actQ : '0;
  end

  assign hbSel = actVec[0];
  assign lbSel = actVec[1];

  always_comb begin
    rdData = '0;
    unique case (strobe.addr)
      ADDR_HB:     rdData = shdVec[0];
      ADDR_LB:     rdData = shdVec[1];
      ADDR_STATUS: rdData = REG_W'(statusQ);
      ADDR_PM:     rdData = {pmMode, spareQ, maskQ, 3'b000};
      ADDR_USID:   rdData = REG_W'(usid);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/rffeSwitchSlave.sv
module rffeSwitchSlave import rffe_sw_pkg::*; #(
  parameter logic [USID_W-1:0] USID_DEFAULT = 4'b1011,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             sdataIn,
  output logic             sdataOut,
  output logic             sdataOe,
  output logic [REG_W-1:0] hbSel,
  output logic [REG_W-1:0] lbSel
);
  regStrobe_t        regStb;
  logic [REG_W-1:0]  rdData;
  logic [USID_W-1:0] usid;

  rffeCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdataIn(sdataIn),
    .usid(usid), .rdData(rdData), .strobe(regStb),
    .sdataOut(sdataOut), .sdataOe(sdataOe)
  );

  rffeRegs #(.USID_DEFAULT(USID_DEFAULT)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(regStb), .rdData(rdData),
    .usid(usid), .hbSel(hbSel), .lbSel(lbSel)
  );
endmodule

// File: rtl/rffeSwitchSlaveChk.sv
module rffeSwitchSlaveChk import rffe_sw_pkg::*; (
  input logic             clk,
  input logic             rstN,
  input logic             sclk,
  input logic             sdataOe,
  input logic [REG_W-1:0] hbSel,
  input logic [REG_W-1:0] lbSel,
  input regStrobe_t       strobe
);
  // R8
  no_write_on_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.errSet != '0) |-> !strobe.wrEn);

  // R7
  oe_on_while_sclk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> sclk);

  // R7
  oe_off_while_sclk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdataOe) |-> !sclk);

  // R4
  hb_held_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrEn) |-> $stable(hbSel));

  // R4
  lb_held_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.wrEn) |-> $stable(lbSel));
endmodule

bind rffeSwitchSlave rffeSwitchSlaveChk i_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .sdataOe(sdataOe),
  .hbSel(hbSel), .lbSel(lbSel), .strobe(regStb)
);

// File: tb/test_rffeSwitchSlave.sv
module test_rffeSwitchSlave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, mData = 1'b0, mOe = 1'b1;
  logic sdataOut, sdataOe, bus;
  logic [7:0] hbSel, lbSel;
  int nChecks = 0, nErr = 0, monFrames = 0, monCnt = 0;
  logic monPark = 1'b0;
  logic [8:0] monBits = '0;

  typedef struct { logic [7:0] val; string tag; } expItem_t;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus = sdataOe ? sdataOut : (mOe ? mData : 1'b0);

  rffeSwitchSlave i_rffeSwitchSlave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdataIn(bus),
    .sdataOut(sdataOut), .sdataOe(sdataOe), .hbSel(hbSel), .lbSel(lbSel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic halfT();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sscT();
    mOe = 1'b1; sclk = 1'b0; mData = 1'b0; halfT();
    mData = 1'b1; halfT();
    mData = 1'b0; halfT();
  endtask

  task automatic bitT(input logic b);
    sclk = 1'b1; mData = b; halfT();
    sclk = 1'b0; halfT();
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitT(v[i]);
  endtask

  task automatic cmdT(input logic [3:0] id, input logic [7:0] cmd, input logic flip);
    logic [11:0] f;
    f = {id, cmd};
    sendBits({3'b000, f, (~^f) ^ flip}, 13);
  endtask

  task automatic reg0Wr(input logic [3:0] id, input logic [6:0] d, input logic flip = 1'b0);
    sscT(); cmdT(id, {1'b1, d}, flip); bitT(1'b0);
  endtask

  task automatic regWr(input logic [3:0] id, input logic [4:0] a, input logic [7:0] d,
                       input logic dflip = 1'b0);
    sscT(); cmdT(id, {3'b010, a}, 1'b0);
    sendBits({7'b0, d, (~^d) ^ dflip}, 9);
    bitT(1'b0);
  endtask

  task automatic regRd(input logic [3:0] id, input logic [4:0] a);
    sscT(); cmdT(id, {3'b011, a}, 1'b0);
    bitT(1'b0);
    mOe = 1'b0;
    repeat (9) bitT(1'b0);
    bitT(1'b0);
    mOe = 1'b1; mData = 1'b0;
  endtask

  // driver side of the scoreboard: queue the expected reply, then issue the read
  task automatic expRead(input logic [3:0] id, input logic [4:0] a, input logic [7:0] v,
                         input string tag);
    expItem_t it;
    it.val = v; it.tag = tag;
    expQ.push_back(it);
    regRd(id, a);
  endtask

  // monitor side: assemble reply frames from the bus and compare
  always @(negedge sclk) begin
    if (!sdataOe) begin
      monCnt  = 0;
      monPark = 1'b0;
    end else if (!monPark) begin
      monBits = {monBits[7:0], bus};
      monCnt++;
      if (monCnt == 9) begin
        expItem_t it;
        monFrames++;
        monPark = 1'b1;
        if (expQ.size() == 0) chk("R7 unexpected reply frame", 1, 0);
        else begin
          it = expQ.pop_front();
          chk(it.tag, {24'b0, monBits[8:1]}, {24'b0, it.val});
          chk("R7 reply parity odd", {31'b0, ^monBits}, 1);
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int f0;
    repeat (5) @(negedge clk);
    chk("R14 hbSel in reset", hbSel, 0);
    chk("R14 lbSel in reset", lbSel, 0);
    chk("R14 sdataOe in reset", sdataOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2: compact write lands in the shadow only
    reg0Wr(4'hB, 7'h55);
    chk("R2 hbSel unchanged by shadow write", hbSel, 8'h00);
    expRead(4'hB, 5'h00, 8'h55, "R1 R2 compact write readback");

    // R4: trigger 0 moves high band
    regWr(4'hB, 5'h1C, 8'h01);
    chk("R4 hbSel after trigger 0", hbSel, 8'h55);
    chk("R4 lbSel untouched by trigger 0", lbSel, 8'h00);
    expRead(4'hB, 5'h1C, 8'h00, "R4 trigger bits read zero");

    // R3 + trigger 1
    regWr(4'hB, 5'h01, 8'hA3);
    chk("R3 lbSel held before trigger", lbSel, 8'h00);
    expRead(4'hB, 5'h01, 8'hA3, "R3 low-band readback");
    regWr(4'hB, 5'h1C, 8'h02);
    chk("R4 lbSel after trigger 1", lbSel, 8'hA3);
    chk("R4 hbSel kept after trigger 1", hbSel, 8'h55);

    // R2 full-width write, trigger 2 for both
    regWr(4'hB, 5'h00, 8'hC6);
    regWr(4'hB, 5'h01, 8'h81);
    chk("R4 hbSel held before trigger 2", hbSel, 8'h55);
    regWr(4'hB, 5'h1C, 8'h04);
    chk("R2 R4 hbSel after trigger 2", hbSel, 8'hC6);
    chk("R4 lbSel after trigger 2", lbSel, 8'h81);

    // R5 masks
    regWr(4'hB, 5'h1C, 8'h08);
    reg0Wr(4'hB, 7'h11);
    chk("R5 high-band mask passes write", hbSel, 8'h11);
    regWr(4'hB, 5'h01, 8'h22);
    chk("R5 unmasked low band held", lbSel, 8'h81);
    regWr(4'hB, 5'h1C, 8'h10);
    regWr(4'hB, 5'h01, 8'h33);
    chk("R5 low-band mask passes write", lbSel, 8'h33);
    reg0Wr(4'hB, 7'h44);
    chk("R5 high band held after unmask", hbSel, 8'h11);
    expRead(4'hB, 5'h1C, 8'h10, "R5 mask readback");

    // R6 power mode
    regWr(4'hB, 5'h1C, 8'h50);
    chk("R6 hbSel forced low", hbSel, 8'h00);
    chk("R6 lbSel forced low", lbSel, 8'h00);
    regWr(4'hB, 5'h1C, 8'h10);
    chk("R6 hbSel restored", hbSel, 8'h11);
    chk("R6 lbSel restored", lbSel, 8'h33);

    // R8 R9 command parity
    reg0Wr(4'hB, 7'h7F, 1'b1);
    expRead(4'hB, 5'h00, 8'h44, "R8 command parity error discarded");
    expRead(4'hB, 5'h1B, 8'h01, "R9 command parity flag");
    expRead(4'hB, 5'h1B, 8'h00, "R9 flags clear on read");

    // R8 R9 data parity (low band masked: a write would show at once)
    regWr(4'hB, 5'h01, 8'h5A, 1'b1);
    chk("R8 data parity error leaves lbSel", lbSel, 8'h33);
    expRead(4'hB, 5'h01, 8'h33, "R8 data parity error discarded");
    expRead(4'hB, 5'h1B, 8'h04, "R9 data parity flag");

    // R11 other slave ID
    reg0Wr(4'h3, 7'h12);
    regWr(4'h3, 5'h01, 8'h66);
    chk("R11 foreign ID leaves lbSel", lbSel, 8'h33);
    expRead(4'hB, 5'h00, 8'h44, "R11 foreign ID leaves shadow");
    expRead(4'hB, 5'h1B, 8'h00, "R11 foreign ID sets no flag");

    // R10 invalid addresses
    regWr(4'hB, 5'h05, 8'h99);
    expRead(4'hB, 5'h1B, 8'h10, "R10 R9 invalid write flag");
    f0 = monFrames;
    regRd(4'hB, 5'h06);
    chk("R10 invalid read gets no reply", monFrames, f0);
    chk("R10 sdataOe idle after invalid read", sdataOe, 0);
    expRead(4'hB, 5'h1B, 8'h08, "R10 R9 invalid read flag");

    // R9 length error, new sequence proceeds
    sscT();
    sendBits(16'h002D, 6);
    reg0Wr(4'hB, 7'h2B);
    regWr(4'hB, 5'h1C, 8'h11);
    chk("R9 sequence after restart applied", hbSel, 8'h2B);
    expRead(4'hB, 5'h1B, 8'h02, "R9 length error flag");

    // R12 slave ID reprogramming
    regWr(4'hB, 5'h1F, 8'h06);
    reg0Wr(4'hB, 7'h01);
    reg0Wr(4'h6, 7'h3E);
    regWr(4'h6, 5'h1C, 8'h11);
    chk("R12 new ID accepted, old ignored", hbSel, 8'h3E);
    expRead(4'h6, 5'h1F, 8'h06, "R12 ID readback");

    // R13 software reset
    regWr(4'h6, 5'h1A, 8'h40);
    chk("R13 hbSel cleared", hbSel, 8'h00);
    chk("R13 lbSel cleared", lbSel, 8'h00);
    expRead(4'h6, 5'h01, 8'h00, "R13 low-band shadow cleared");
    expRead(4'h6, 5'h1C, 8'h10, "R13 trigger register kept, ID kept");
    expRead(4'h6, 5'h1A, 8'h00, "R13 reset bit reads zero");

    halfT(); halfT();
    chk("R7 every expected reply seen", expQ.size(), 0);
    chk("R7 SDATA released at end", sdataOe, 0);
    summary();
    $finish;
  end
endmodule